// File: doc/BRIEF.md
# Aliased Monitoring Register Bank with Pointer Stepping

This block stores the 32-byte value area of a hardware monitor. The first eleven bytes hold measurement results, the next nineteen hold limit values, and the last two are reserved. A host reaches the storage through a 7-bit internal pointer. The same physical bytes appear at two address windows: a lower window at 20h–3Fh and an upper mirror at 60h–7Fh. The lower five pointer bits select the byte.

The host first loads the pointer, then reads or writes data at the pointed byte. One input tags the access as coming from the parallel bus or from the serial bus. When the access comes from the parallel bus and the pointer sits in the upper window, each data read or write steps the pointer by one. This lets the host stream through the bank. Lower-window accesses, serial accesses and out-of-window accesses leave the pointer where it is.

A separate port lets the measurement engine write the eleven result bytes directly.

Top module: `mirror_vram`

## Requirements
- R1: While reset is high, the pointer becomes 00h and every stored byte becomes 00h at the next clock edge.
- R2: A pointer load strobe writes the 7-bit load value into the pointer at the next edge. This load takes priority over any stepping in the same cycle. A data write in that same cycle still lands at the old pointer.
- R3: Pointer values 20h–3Fh and 60h–7Fh both select the stored byte at offset pointer[4:0]. A byte written through one window reads back identically through the other.
- R4: A parallel access (host_serial = 0) with a read or write strobe, while the pointer is in 60h–7Fh, makes the pointer one higher after the edge.
- R5: Stepping from 7Fh gives 60h, so the pointer never leaves the upper window by stepping.
- R6: An access with host_serial = 1 never changes the pointer, at any address.
- R7: Accesses while the pointer is in 20h–3Fh never change the pointer.
- R8: Offsets 1Eh and 1Fh read as 00h in both windows, and writes to them have no effect.
- R9: For pointer values 00h–1Fh and 40h–5Fh, reads return 00h, writes have no effect and the pointer does not step.
- R10: The result port writes res_wdata to offset res_idx for res_idx 0–10. Values of res_idx of 11 or above are ignored.
- R11: If a host write and a result write hit the same byte in one cycle, the byte takes the host data.
- R12: host_rdata shows, without a clock delay, the byte selected by the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ptr_we | input | 1 | Load the pointer |
| host_ptr_wdata | input | 7 | New pointer value |
| host_rd | input | 1 | Data read strobe |
| host_wr | input | 1 | Data write strobe |
| host_wdata | input | 8 | Data to write |
| host_serial | input | 1 | 1 = access from the serial bus, 0 = parallel bus |
| host_rdata | output | 8 | Byte at the current pointer |
| host_ptr | output | 7 | Current pointer value |
| res_we | input | 1 | Result write strobe |
| res_idx | input | 4 | Result byte index |
| res_wdata | input | 8 | Result data |

## Verification
The properties assume that reset is high on the first clock and that every input has a known level at each rising edge. Under those conditions the pointer's next value depends only on the strobes and on the current pointer window. The stimulus changes inputs only on falling edges, starts from a three-cycle reset, and then mixes directed windows (wrap, serial, out-of-window, collision) with random strobes. Pointer loads in the random phase may target any of the 128 values.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 5;
    localparam int WIN_N  = 1 << OFF_W;
    localparam int RES_N  = 11;
    localparam int LIM_N  = 19;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        logic hit;
        logic upper;
        logic live;
        off_t off;
    } dec_t;

    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_STEP = 2'd2
    } ptr_op_e;

    // Bit OFF_W marks either window; the top bit separates upper from lower.
    function automatic dec_t decode(addr_t a, int live_n);
        dec_t d;
        d.off   = a[OFF_W-1:0];
        d.hit   = a[OFF_W];
        d.upper = a[ADDR_W-1] & a[OFF_W];
        d.live  = a[OFF_W] && (int'(a[OFF_W-1:0]) < live_n);
        return d;
    endfunction

    function automatic addr_t step_in_window(addr_t a);
        off_t nxt;
        nxt = a[OFF_W-1:0] + off_t'(1);
        return {a[ADDR_W-1:OFF_W], nxt};
    endfunction
endpackage

// File: rtl/mvr_ptr.sv
module mvr_ptr
    import mvr_pkg::*;
#(
    parameter int LIVE_N = RES_N + LIM_N
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  addr_t ld_val,
    input  logic  access,
    input  logic  serial,
    output addr_t ptr
);
    dec_t    d;
    ptr_op_e op;

    always_comb begin
        d = decode(ptr, LIVE_N);
        if (ld)
            op = PTR_LOAD;
        else if (access && !serial && d.upper)
            op = PTR_STEP;
        else
            op = PTR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            case (op)
                PTR_LOAD: ptr <= ld_val;
                PTR_STEP: ptr <= step_in_window(ptr);
                default:  ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/mvr_store.sv
module mvr_store
    import mvr_pkg::*;
#(
    parameter int N_RES  = RES_N,
    parameter int N_LIM  = LIM_N,
    parameter int IDX_W  = $clog2(N_RES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  off_t             host_off,
    input  byte_t            host_wdata,
    input  logic             res_we,
    input  logic [IDX_W-1:0] res_idx,
    input  byte_t            res_wdata,
    input  off_t             rd_off,
    output byte_t            rd_data
);
    localparam int LIVE_N = N_RES + N_LIM;

    byte_t view [WIN_N];

    for (genvar i = 0; i < WIN_N; i++) begin : g_cell
        if (i < N_RES) begin : g_res
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (host_we && host_off == off_t'(i))
                    q <= host_wdata;
                else if (res_we && res_idx == IDX_W'(i))
                    q <= res_wdata;
            end
            assign view[i] = q;
        end else if (i < LIVE_N) begin : g_lim
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (host_we && host_off == off_t'(i))
                    q <= host_wdata;
            end
            assign view[i] = q;
        end else begin : g_pad
            assign view[i] = '0;
        end
    end

    assign rd_data = view[rd_off];
endmodule

// File: rtl/mirror_vram.sv
module mirror_vram
    import mvr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_ptr_we,
    input  logic [6:0]  host_ptr_wdata,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    input  logic        host_serial,
    output logic [7:0]  host_rdata,
    output logic [6:0]  host_ptr,
    input  logic        res_we,
    input  logic [3:0]  res_idx,
    input  logic [7:0]  res_wdata
);
    localparam int LIVE_N = RES_N + LIM_N;

    addr_t ptr_q;
    dec_t  d;
    byte_t cell_rd;
    logic  host_we_live;

    mvr_ptr #(.LIVE_N(LIVE_N)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (host_ptr_we),
        .ld_val (host_ptr_wdata),
        .access (host_rd | host_wr),
        .serial (host_serial),
        .ptr    (ptr_q)
    );

    always_comb begin
        d            = decode(ptr_q, LIVE_N);
        host_we_live = host_wr && d.live;
    end

    mvr_store #(.N_RES(RES_N), .N_LIM(LIM_N), .IDX_W(4)) u_store (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we_live),
        .host_off   (d.off),
        .host_wdata (host_wdata),
        .res_we     (res_we),
        .res_idx    (res_idx),
        .res_wdata  (res_wdata),
        .rd_off     (d.off),
        .rd_data    (cell_rd)
    );

    assign host_rdata = d.hit ? cell_rd : '0;
    assign host_ptr   = ptr_q;
endmodule

// File: rtl/mirror_vram_chk.sv
module mirror_vram_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_ptr_we,
    input logic [6:0] host_ptr_wdata,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       host_serial,
    input logic [7:0] host_rdata,
    input logic [6:0] host_ptr
);
    a_r1_ptr_cleared: assert property (@(posedge clk) rst |=> host_ptr == 7'h00);

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
        host_ptr_we |=> host_ptr == $past(host_ptr_wdata));

    a_r4_r5_step: assert property (@(posedge clk) disable iff (rst)
        (!host_ptr_we && !host_serial && (host_rd || host_wr) && host_ptr[6:5] == 2'b11)
        |=> host_ptr == {2'b11, $past(host_ptr[4:0]) + 5'd1});

    a_r6_serial_hold: assert property (@(posedge clk) disable iff (rst)
        (!host_ptr_we && host_serial) |=> $stable(host_ptr));

    a_r7_r9_no_step: assert property (@(posedge clk) disable iff (rst)
        (!host_ptr_we && host_ptr[6:5] != 2'b11) |=> $stable(host_ptr));

    a_r9_outside_zero: assert property (@(posedge clk) disable iff (rst)
        !host_ptr[5] |-> host_rdata == 8'h00);

    a_r8_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (host_ptr[5] && host_ptr[4:0] >= 5'd30) |-> host_rdata == 8'h00);

    a_r11_host_lands: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_ptr_we && host_ptr[6:5] == 2'b01 && host_ptr[4:0] < 5'd30)
        |=> host_rdata == $past(host_wdata));
endmodule

bind mirror_vram mirror_vram_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_ptr_we    (host_ptr_we),
    .host_ptr_wdata (host_ptr_wdata),
    .host_rd        (host_rd),
    .host_wr        (host_wr),
    .host_wdata     (host_wdata),
    .host_serial    (host_serial),
    .host_rdata     (host_rdata),
    .host_ptr       (host_ptr)
);

// File: tb/sim_mirror_vram.sv
module sim_mirror_vram;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       p_we = 1'b0;
    logic [6:0] p_wdata = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       serial = 1'b0;
    logic       r_we = 1'b0;
    logic [3:0] r_idx = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] dut_rdata;
    logic [6:0] dut_ptr;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    int m_ptr;
    int m_mem [32];

    always #4 clk = ~clk;

    mirror_vram u0 (
        .clk(clk), .rst(rst),
        .host_ptr_we(p_we), .host_ptr_wdata(p_wdata),
        .host_rd(rd), .host_wr(wr), .host_wdata(wdata),
        .host_serial(serial),
        .host_rdata(dut_rdata), .host_ptr(dut_ptr),
        .res_we(r_we), .res_idx(r_idx), .res_wdata(r_wdata)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    function automatic int exp_rdata();
        int off;
        off = m_ptr % 32;
        if (((m_ptr >> 5) & 1) == 1 && off < 30) return m_mem[off];
        return 0;
    endfunction

    task automatic model_update();
        int off;
        bit live;
        off  = m_ptr % 32;
        live = (((m_ptr >> 5) & 1) == 1) && off < 30;
        if (rst) begin
            m_ptr = 0;
            for (int i = 0; i < 32; i++) m_mem[i] = 0;
        end else begin
            if (r_we && r_idx < 11) m_mem[r_idx] = r_wdata;
            if (wr && live) m_mem[off] = wdata;
            if (p_we) m_ptr = p_wdata;
            else if ((rd || wr) && !serial && m_ptr >= 'h60)
                m_ptr = 'h60 + ((off + 1) % 32);
        end
    endtask

    task automatic step();
        @(posedge clk);
        cycles++;
        model_update();
        @(negedge clk);
        chk("pointer", dut_ptr, m_ptr);
        chk("rdata", dut_rdata, exp_rdata());
    endtask

    task automatic idle();
        p_we = 0; rd = 0; wr = 0; serial = 0; r_we = 0;
    endtask

    task automatic load(int a);
        idle(); p_we = 1; p_wdata = 7'(a); step(); idle();
    endtask

    task automatic hwrite(int v, bit ser);
        idle(); wr = 1; wdata = 8'(v); serial = ser; step(); idle();
    endtask

    task automatic hread(bit ser);
        idle(); rd = 1; serial = ser; step(); idle();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 0;
        m_ptr = 0;
        @(negedge clk);
        cur_req = "R1";
        rst = 1;
        repeat (3) step();
        chk("reset pointer R1", dut_ptr, 0);
        rst = 0;
        step();

        cur_req = "R10";
        for (int i = 0; i < 16; i++) begin
            idle(); r_we = 1; r_idx = 4'(i); r_wdata = 8'(8'h40 + i); step();
        end
        idle();
        load('h2C);
        chk("idx 12 ignored R10", dut_rdata, 0);

        cur_req = "R7";
        load('h25);
        hwrite('h5A, 0);
        chk("lower hold R7", dut_ptr, 'h25);
        hread(0);
        chk("lower read R7", dut_rdata, 'h5A);

        cur_req = "R3";
        load('h65);
        chk("mirror alias R3", dut_rdata, 'h5A);
        load('h70);
        hwrite('hC3, 1);
        load('h30);
        chk("lower sees mirror write R3", dut_rdata, 'hC3);

        cur_req = "R4";
        load('h60);
        for (int i = 0; i < 40; i++) hwrite(i + 1, 0);
        chk("after 40 steps R4", dut_ptr, 'h68);

        cur_req = "R5";
        load('h7E);
        hread(0);
        hread(0);
        chk("wrap to 60h R5", dut_ptr, 'h60);

        cur_req = "R8";
        load('h7E);
        chk("pad 1Eh R8", dut_rdata, 0);
        load('h3F);
        hwrite('hFF, 0);
        chk("pad write ignored R8", dut_rdata, 0);

        cur_req = "R6";
        load('h62);
        for (int i = 0; i < 5; i++) hwrite(8'h90 + i, 1);
        hread(1);
        chk("serial hold R6", dut_ptr, 'h62);

        cur_req = "R9";
        load('h10);
        hwrite('h77, 0);
        chk("outside read R9", dut_rdata, 0);
        load('h45);
        hread(0);
        chk("outside no step R9", dut_ptr, 'h45);

        cur_req = "R11";
        load('h23);
        idle(); wr = 1; wdata = 8'hAA; r_we = 1; r_idx = 4'd3; r_wdata = 8'h55; step(); idle();
        chk("host wins R11", dut_rdata, 'hAA);

        cur_req = "R2";
        load('h64);
        idle(); p_we = 1; p_wdata = 7'h2A; wr = 1; wdata = 8'h3C; step(); idle();
        chk("load beats step R2", dut_ptr, 'h2A);
        load('h24);
        chk("write at old pointer R2", dut_rdata, 'h3C);

        cur_req = "R12";
        for (int i = 0; i < 400; i++) begin
            idle();
            p_we    = ($urandom % 8) == 0;
            p_wdata = 7'($urandom);
            rd      = $urandom % 2;
            wr      = $urandom % 2;
            wdata   = 8'($urandom);
            serial  = ($urandom % 4) == 0;
            r_we    = $urandom % 2;
            r_idx   = 4'($urandom);
            r_wdata = 8'($urandom);
            step();
        end
        idle();
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule